// File: doc/BRIEF.md
# SPI Register Bank with One-Frame Delayed Readback

This block is the serial control interface of a four-channel output controller. A host exchanges 16-bit frames over a four-wire serial link (clock, active-low select, data in, data out). Each incoming frame carries a write flag, a 5-bit register address and a 4-bit data value. It either loads a configuration register or only selects one for reading. Registers are split into per-channel groups, picked by a 2-bit channel number in the top address bits, and a set of global registers.

The word shifted back during a frame reports the current state and the result of the previous frame. It holds the watchdog pin level, the undervoltage and overvoltage flags, the address committed on the previous frame, four channel state bits, and four data bits read from the register that previous address names. Every read therefore completes one frame after it is issued. A latched fault register per channel collects single-cycle fault pulses. It drives a shared fault output and is cleared when that channel is commanded off.

The serial pins are assumed to be synchronous to the system clock and slower than it; every serial event is found by comparing a pin with its value one system clock earlier.

Top module: `spi_regbank`

## Requirements
- R1: The returned word is shifted out MSB first. Its layout is: bit 15 watchdog pin, bit 14 undervoltage flag, bit 13 overvoltage flag, bits 12..8 the previously committed address, bits 7..4 the channel state inputs, bits 3..0 read data. Data in is sampled on rising serial clock edges, and data out advances on falling edges.
- R2: Bits 3..0 of the returned word come from the register named by the address committed on the previous frame. Bits 12..8 echo that same address.
- R3: A frame takes effect on the rising edge of select only if exactly 16 rising clock edges were seen while select was low. With 15 or 17 edges, nothing is written and the previous address is kept.
- R4: The incoming frame holds the write flag in bit 15, the address in bits 14..10 and the data in bits 3..0; bits 9..4 are ignored. Address {ch,010} writes the overcurrent level of channel ch, {ch,011} its timing configuration, and {ch,100} its drive configuration. Each of these is 4 bits and appears at output bits ch*4+3..ch*4.
- R5: Global registers: 00001 holds the channel on commands, 01001 the sense enables, and 00101 the voltage configuration (all 4 bits). Address 01101 stores watchdog configuration bits 1..0; when read, its bit 3 is 0 and its bit 2 is the watchdog timeout input.
- R6: Reading {ch,000} returns the latched faults of channel ch: bit 3 overtemperature, bit 2 overcurrent high, bit 1 overcurrent low, bit 0 open load.
- R7: Input fault_set bit ch*4+k latches fault bit k of channel ch. The shared fault output is the OR of all latched faults.
- R8: A committed write to 00001 with bit ch equal to 0 clears all four faults of channel ch. A fault pulse in the same cycle still sets its flag.
- R9: Reading 00110 returns pin group A, 01110 returns pin group B, and 01111 returns {pin group C, 2'b00}. Any other address without a register reads 0. Writes to read-only or undefined addresses change nothing.
- R10: After reset all registers and faults are zero, and the first frame returns an all-zero word.
- R11: Data out is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| wdog_pin | input | 1 | Watchdog pin level for bit 15 |
| undervolt | input | 1 | Undervoltage flag for bit 14 |
| overvolt | input | 1 | Overvoltage flag for bit 13 |
| chan_state | input | 4 | Channel state bits for bits 7..4 |
| wd_timeout | input | 1 | Watchdog timeout status, read at 01101 bit 2 |
| pin_grp_a | input | 4 | Read-only pin group at 00110 |
| pin_grp_b | input | 4 | Read-only pin group at 01110 |
| pin_grp_c | input | 2 | Read-only pin group at 01111 bits 3..2 |
| fault_set | input | 16 | Single-cycle fault pulses, channel-major |
| ch_on | output | 4 | Channel on commands |
| sense_en | output | 4 | Sense enables |
| volt_cfg | output | 4 | Voltage monitor configuration |
| wdog_cfg | output | 2 | Watchdog configuration |
| oc_lvl | output | 16 | Overcurrent levels, 4 bits per channel |
| timing_cfg | output | 16 | Timing configuration, 4 bits per channel |
| drive_cfg | output | 16 | Drive configuration, 4 bits per channel |
| fault_any | output | 1 | OR of all latched faults |

## Verification
The bench writes a register and then reads it on a later frame, checking that the data and echoed address arrive one frame late. A design that returns the current frame's register would show a shifted sequence on every read. Frames of 15 and 17 clocks are sent to show that a frame with the wrong length neither writes nor moves the echoed address; a block that committed on any select edge would change ch_on or the echo. A fault pulse is made to coincide with the commit of a channel-off write. Clear-over-set priority would then lose that fault, and a channel-off write that cleared every channel would wipe faults it should keep. The first frame after reset is checked for all zeros even though the status inputs are high, and the watchdog read is checked with the timeout input both low and high.

// File: rtl/spi_regbank_pkg.sv
`timescale 1ns/1ps
// Shared sizes, address codes and frame field positions of the register bank.
package spi_regbank_pkg;
    localparam int FRAME_W  = 16;             // bits per serial frame
    localparam int ADDR_W   = 5;              // register address width
    localparam int DATA_W   = 4;              // register data width
    localparam int NCH      = 4;              // output channels (must equal DATA_W)
    localparam int FLT_W    = 4;              // fault flags per channel
    localparam int WDOG_W   = 2;              // stored watchdog bits
    localparam int CH_W     = $clog2(NCH);    // channel field in address
    localparam int SUF_W    = ADDR_W - CH_W;  // register suffix in address
    localparam int WR_POS   = FRAME_W - 1;    // write flag position
    localparam int ADDR_LSB = WR_POS - ADDR_W;// address low bit position

    // Per-channel suffixes
    localparam logic [SUF_W-1:0] SUF_FAULT  = 3'b000;
    localparam logic [SUF_W-1:0] SUF_OCLVL  = 3'b010;
    localparam logic [SUF_W-1:0] SUF_TIMING = 3'b011;
    localparam logic [SUF_W-1:0] SUF_DRIVE  = 3'b100;

    // Global addresses
    localparam logic [ADDR_W-1:0] ADR_CHON  = 5'b00001;
    localparam logic [ADDR_W-1:0] ADR_SENSE = 5'b01001;
    localparam logic [ADDR_W-1:0] ADR_VOLT  = 5'b00101;
    localparam logic [ADDR_W-1:0] ADR_WDOG  = 5'b01101;
    localparam logic [ADDR_W-1:0] ADR_PINA  = 5'b00110;
    localparam logic [ADDR_W-1:0] ADR_PINB  = 5'b01110;
    localparam logic [ADDR_W-1:0] ADR_PINC  = 5'b01111;
endpackage

// File: rtl/spi_regbank_frame.sv
`timescale 1ns/1ps
// Serial frame engine. Detects select and clock edges by comparing the pins
// with their value one system clock earlier, shifts data in on rising clock
// edges and data out on falling clock edges, and flags a commit when select
// rises after exactly FW rising clock edges.
// Assumes: serial pins synchronous to clk, each level held >= 2 clk cycles.
module spi_regbank_frame
    import spi_regbank_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [FW-1:0]     tx_word,
    output logic              miso,
    output logic              commit,
    output logic              rx_wr,
    output logic [ADDR_W-1:0] rx_addr,
    output logic [DATA_W-1:0] rx_data
);
    localparam int CNT_W = $clog2(FW + 2);

    logic             sclk_d, cs_d;
    logic             cs_fall, cs_rise, sck_rise, sck_fall;
    logic [CNT_W-1:0] bit_cnt;
    logic [FW-1:0]    rx_sh, tx_sh;

    assign cs_fall  = cs_d & ~cs_n;
    assign cs_rise  = ~cs_d & cs_n;
    assign sck_rise = ~sclk_d & sclk & ~cs_n;
    assign sck_fall = sclk_d & ~sclk & ~cs_n;

    // Remember last pin levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
        end
    end

    // Count rising clock edges in the frame, saturating one past FW
    always_ff @(posedge clk) begin
        if (!rst_n)                                     bit_cnt <= '0;
        else if (cs_fall)                               bit_cnt <= '0;
        else if (sck_rise && bit_cnt <= CNT_W'(FW))     bit_cnt <= bit_cnt + 1'b1;
    end

    // Receive shifter, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_sh <= '0;
        else if (sck_rise) rx_sh <= {rx_sh[FW-2:0], mosi};
    end

    // Transmit shifter: load at select fall, empty at select rise
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_sh <= '0;
        else if (cs_fall)  tx_sh <= tx_word;
        else if (cs_rise)  tx_sh <= '0;
        else if (sck_fall) tx_sh <= tx_sh << 1;
    end

    assign miso    = tx_sh[FW-1];
    assign commit  = cs_rise && (bit_cnt == CNT_W'(FW));
    assign rx_wr   = rx_sh[WR_POS];
    assign rx_addr = rx_sh[ADDR_LSB +: ADDR_W];
    assign rx_data = rx_sh[DATA_W-1:0];

    // R3: edge counter never runs past its saturation value
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FW + 1));

    // R11: output is quiet once select has been high for a full cycle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !miso);
endmodule

// File: rtl/spi_regbank_regs.sv
`timescale 1ns/1ps
// Register storage: global configuration, per-channel configuration and the
// latched per-channel fault flags. Writes arrive only on committed frames.
// Assumes: NCH equals DATA_W so the on-command word has one bit per channel.
module spi_regbank_regs
    import spi_regbank_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [NCH*FLT_W-1:0]   fault_set,
    output logic [NCH-1:0]         ch_on,
    output logic [DATA_W-1:0]      sense_en,
    output logic [DATA_W-1:0]      volt_cfg,
    output logic [WDOG_W-1:0]      wdog_cfg,
    output logic [NCH*DATA_W-1:0]  oc_lvl,
    output logic [NCH*DATA_W-1:0]  timing_cfg,
    output logic [NCH*DATA_W-1:0]  drive_cfg,
    output logic [NCH*FLT_W-1:0]   fault_flags
);
    // Global registers written by full-address match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_on    <= '0;
            sense_en <= '0;
            volt_cfg <= '0;
            wdog_cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CHON:  ch_on    <= wr_data[NCH-1:0];
                ADR_SENSE: sense_en <= wr_data;
                ADR_VOLT:  volt_cfg <= wr_data;
                ADR_WDOG:  wdog_cfg <= wr_data[WDOG_W-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              hit, off_cmd;
        logic [DATA_W-1:0] oc_q, tim_q, drv_q;
        logic [FLT_W-1:0]  flt_q, set_v;

        assign hit     = wr_en && (wr_addr[ADDR_W-1 -: CH_W] == CH_W'(c));
        assign off_cmd = wr_en && (wr_addr == ADR_CHON) && !wr_data[c];
        assign set_v   = fault_set[c*FLT_W +: FLT_W];

        // Per-channel configuration selected by suffix
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oc_q  <= '0;
                tim_q <= '0;
                drv_q <= '0;
            end else if (hit) begin
                case (wr_addr[SUF_W-1:0])
                    SUF_OCLVL:  oc_q  <= wr_data;
                    SUF_TIMING: tim_q <= wr_data;
                    SUF_DRIVE:  drv_q <= wr_data;
                    default:    ;
                endcase
            end
        end

        // Fault latch: off command clears, a pulse in the same cycle still sets
        always_ff @(posedge clk) begin
            if (!rst_n) flt_q <= '0;
            else        flt_q <= (off_cmd ? '0 : flt_q) | set_v;
        end

        assign oc_lvl[c*DATA_W +: DATA_W]     = oc_q;
        assign timing_cfg[c*DATA_W +: DATA_W] = tim_q;
        assign drive_cfg[c*DATA_W +: DATA_W]  = drv_q;
        assign fault_flags[c*FLT_W +: FLT_W]  = flt_q;

        // R8: an off command with no pulse leaves the channel fault-free
        a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (off_cmd && set_v == '0) |=> (flt_q == '0));

        // R7: every pulsed fault is latched on the next cycle
        a_r7_pulse_latches: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v != '0) |=> ((flt_q & $past(set_v)) == $past(set_v)));
    end
endmodule

// File: rtl/spi_regbank_rdmux.sv
`timescale 1ns/1ps
// Readback selector: returns the 4-bit data of the register named by an
// address. Per-channel suffixes are decoded first, then global addresses;
// anything else reads as zero.
// Assumes: addr is the address committed on the previous frame.
module spi_regbank_rdmux
    import spi_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NCH-1:0]         ch_on,
    input  logic [DATA_W-1:0]      sense_en,
    input  logic [DATA_W-1:0]      volt_cfg,
    input  logic [WDOG_W-1:0]      wdog_cfg,
    input  logic                   wd_timeout,
    input  logic [NCH*DATA_W-1:0]  oc_lvl,
    input  logic [NCH*DATA_W-1:0]  timing_cfg,
    input  logic [NCH*DATA_W-1:0]  drive_cfg,
    input  logic [NCH*FLT_W-1:0]   fault_flags,
    input  logic [DATA_W-1:0]      pin_grp_a,
    input  logic [DATA_W-1:0]      pin_grp_b,
    input  logic [1:0]             pin_grp_c,
    output logic [DATA_W-1:0]      rdata
);
    logic [CH_W-1:0]  sel_ch;
    logic [SUF_W-1:0] suf;

    assign sel_ch = addr[ADDR_W-1 -: CH_W];
    assign suf    = addr[SUF_W-1:0];

    // Select read data for the addressed register
    always_comb begin
        rdata = '0;
        case (suf)
            SUF_FAULT:  rdata = fault_flags[sel_ch*FLT_W +: FLT_W];
            SUF_OCLVL:  rdata = oc_lvl[sel_ch*DATA_W +: DATA_W];
            SUF_TIMING: rdata = timing_cfg[sel_ch*DATA_W +: DATA_W];
            SUF_DRIVE:  rdata = drive_cfg[sel_ch*DATA_W +: DATA_W];
            default: begin
                case (addr)
                    ADR_CHON:  rdata = ch_on;
                    ADR_SENSE: rdata = sense_en;
                    ADR_VOLT:  rdata = volt_cfg;
                    ADR_WDOG:  rdata = {1'b0, wd_timeout, wdog_cfg};
                    ADR_PINA:  rdata = pin_grp_a;
                    ADR_PINB:  rdata = pin_grp_b;
                    ADR_PINC:  rdata = {pin_grp_c, 2'b00};
                    default:   rdata = '0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/spi_regbank.sv
`timescale 1ns/1ps
// Top of the serial register bank. Ties the frame engine, storage and read
// selector together, keeps the previously committed address and builds the
// returned word from status inputs and the delayed readback.
// Assumes: serial pins synchronous to clk; first frame after reset returns 0.
module spi_regbank
    import spi_regbank_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sclk,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    input  logic                   wdog_pin,
    input  logic                   undervolt,
    input  logic                   overvolt,
    input  logic [NCH-1:0]         chan_state,
    input  logic                   wd_timeout,
    input  logic [DATA_W-1:0]      pin_grp_a,
    input  logic [DATA_W-1:0]      pin_grp_b,
    input  logic [1:0]             pin_grp_c,
    input  logic [NCH*FLT_W-1:0]   fault_set,
    output logic [NCH-1:0]         ch_on,
    output logic [DATA_W-1:0]      sense_en,
    output logic [DATA_W-1:0]      volt_cfg,
    output logic [WDOG_W-1:0]      wdog_cfg,
    output logic [NCH*DATA_W-1:0]  oc_lvl,
    output logic [NCH*DATA_W-1:0]  timing_cfg,
    output logic [NCH*DATA_W-1:0]  drive_cfg,
    output logic                   fault_any
);
    logic                   commit, rx_wr, first_q;
    logic [ADDR_W-1:0]      rx_addr, prev_addr;
    logic [DATA_W-1:0]      rx_data, rdata;
    logic [FRAME_W-1:0]     tx_word;
    logic [NCH*FLT_W-1:0]   fault_flags;

    spi_regbank_frame #(.FW(FRAME_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .tx_word(tx_word), .miso(spi_miso),
        .commit(commit), .rx_wr(rx_wr), .rx_addr(rx_addr), .rx_data(rx_data)
    );

    spi_regbank_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(commit && rx_wr),
        .wr_addr(rx_addr), .wr_data(rx_data), .fault_set(fault_set),
        .ch_on(ch_on), .sense_en(sense_en), .volt_cfg(volt_cfg),
        .wdog_cfg(wdog_cfg), .oc_lvl(oc_lvl), .timing_cfg(timing_cfg),
        .drive_cfg(drive_cfg), .fault_flags(fault_flags)
    );

    spi_regbank_rdmux u_rdmux (
        .addr(prev_addr), .ch_on(ch_on), .sense_en(sense_en),
        .volt_cfg(volt_cfg), .wdog_cfg(wdog_cfg), .wd_timeout(wd_timeout),
        .oc_lvl(oc_lvl), .timing_cfg(timing_cfg), .drive_cfg(drive_cfg),
        .fault_flags(fault_flags), .pin_grp_a(pin_grp_a),
        .pin_grp_b(pin_grp_b), .pin_grp_c(pin_grp_c), .rdata(rdata)
    );

    // Capture the committed address; leave first-frame state after a commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            first_q   <= 1'b1;
        end else if (commit) begin
            prev_addr <= rx_addr;
            first_q   <= 1'b0;
        end
    end

    assign tx_word   = first_q ? '0 :
                       {wdog_pin, undervolt, overvolt, prev_addr, chan_state, rdata};
    assign fault_any = |fault_flags;

    // R2/R3: echoed address moves only after a committed frame
    a_r2_prev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prev_addr) |-> $past(commit));

    // R7: shared fault output rises only after a fault pulse
    a_r7_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_any) |-> $past(|fault_set));

    // R10: first frame after reset starts with a zero output bit
    a_r10_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && first_q) |=> !spi_miso);
endmodule

// File: tb/spi_regbank_test.sv
`timescale 1ns/1ps
module spi_regbank_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso;
    logic        wdog_pin = 0, undervolt = 0, overvolt = 0, wd_timeout = 0;
    logic [3:0]  chan_state = 0, pin_grp_a = 0, pin_grp_b = 0;
    logic [1:0]  pin_grp_c = 0;
    logic [15:0] fault_set = 0;
    logic [3:0]  ch_on, sense_en, volt_cfg;
    logic [1:0]  wdog_cfg;
    logic [15:0] oc_lvl, timing_cfg, drive_cfg;
    logic        fault_any;

    int errors = 0, checks = 0;
    bit cmp_on = 0, done = 0;

    // Reference state
    logic [3:0] m_chon = 0, m_sense = 0, m_volt = 0;
    logic [1:0] m_wdog = 0;
    logic [3:0] m_oc[4], m_tim[4], m_drv[4], m_flt[4];
    logic [4:0] m_prev = 0;
    bit         m_first = 1;

    always #10 clk = ~clk;

    spi_regbank uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .wdog_pin(wdog_pin),
        .undervolt(undervolt), .overvolt(overvolt), .chan_state(chan_state),
        .wd_timeout(wd_timeout), .pin_grp_a(pin_grp_a), .pin_grp_b(pin_grp_b),
        .pin_grp_c(pin_grp_c), .fault_set(fault_set), .ch_on(ch_on),
        .sense_en(sense_en), .volt_cfg(volt_cfg), .wdog_cfg(wdog_cfg),
        .oc_lvl(oc_lvl), .timing_cfg(timing_cfg), .drive_cfg(drive_cfg),
        .fault_any(fault_any)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_rd(input logic [4:0] a);
        int ch = int'(a[4:3]);
        case (a[2:0])
            3'b000: return m_flt[ch];
            3'b010: return m_oc[ch];
            3'b011: return m_tim[ch];
            3'b100: return m_drv[ch];
            default: ;
        endcase
        case (a)
            5'b00001: return m_chon;
            5'b01001: return m_sense;
            5'b00101: return m_volt;
            5'b01101: return {1'b0, wd_timeout, m_wdog};
            5'b00110: return pin_grp_a;
            5'b01110: return pin_grp_b;
            5'b01111: return {pin_grp_c, 2'b00};
            default:  return 4'h0;
        endcase
    endfunction

    task automatic m_apply(input logic wr, input logic [4:0] a, input logic [3:0] d);
        if (wr) begin
            case (a[2:0])
                3'b010: m_oc[a[4:3]]  = d;
                3'b011: m_tim[a[4:3]] = d;
                3'b100: m_drv[a[4:3]] = d;
                default: ;
            endcase
            case (a)
                5'b00001: begin
                    m_chon = d;
                    for (int c = 0; c < 4; c++) if (!d[c]) m_flt[c] = 4'h0;
                end
                5'b01001: m_sense = d;
                5'b00101: m_volt  = d;
                5'b01101: m_wdog  = d[1:0];
                default: ;
            endcase
        end
        m_prev  = a;
        m_first = 0;
    endtask

    // One frame of nclk clock pulses; every returned bit is compared (R1).
    task automatic frame(input logic wr, input logic [4:0] a, input logic [3:0] d,
                         input int nclk, input string tag, input int coll = -1);
        logic [15:0] w, exp;
        w   = {wr, a, 6'b0, d};
        exp = m_first ? 16'h0 :
              {wdog_pin, undervolt, overvolt, m_prev, chan_state, m_rd(m_prev)};
        @(negedge clk) cs_n = 0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i < 16) check($sformatf("%s R1 bit%0d addr=%b", tag, 15-i, a), miso, exp[15-i]);
            sclk = 1;
            repeat (4) @(negedge clk);
            sclk = 0;
            repeat (4) @(negedge clk);
        end
        cs_n = 1;
        if (nclk == 16) m_apply(wr, a, d);
        if (coll >= 0) begin
            fault_set[coll] = 1'b1;
            m_flt[coll/4][coll%4] = 1'b1;
        end
        @(negedge clk) fault_set = '0;
        repeat (3) @(negedge clk);
        check("R11 idle miso", miso, 0);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk) fault_set[idx] = 1'b1;
        m_flt[idx/4][idx%4] = 1'b1;
        @(negedge clk) fault_set = '0;
    endtask

    // Per-clock comparison of the register outputs against the model
    always @(posedge clk) begin
        #5;
        if (cmp_on && !done) begin
            check("R5 ch_on", ch_on, m_chon);
            check("R5 sense_en", sense_en, m_sense);
            check("R5 volt_cfg", volt_cfg, m_volt);
            check("R5 wdog_cfg", wdog_cfg, m_wdog);
            check("R4 oc_lvl", oc_lvl, {m_oc[3], m_oc[2], m_oc[1], m_oc[0]});
            check("R4 timing_cfg", timing_cfg, {m_tim[3], m_tim[2], m_tim[1], m_tim[0]});
            check("R4 drive_cfg", drive_cfg, {m_drv[3], m_drv[2], m_drv[1], m_drv[0]});
            check("R7 fault_any", fault_any, |{m_flt[3], m_flt[2], m_flt[1], m_flt[0]});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            m_oc[c] = 0; m_tim[c] = 0; m_drv[c] = 0; m_flt[c] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 reset ch_on", ch_on, 0);
        check("R10 reset oc_lvl", oc_lvl, 0);
        check("R10 reset fault_any", fault_any, 0);
        check("R10 reset miso", miso, 0);
        cmp_on = 1;

        wdog_pin = 1; overvolt = 1; chan_state = 4'b1010;
        pin_grp_a = 4'h9; pin_grp_b = 4'h6; pin_grp_c = 2'b10;

        // R10: first word zero despite live status inputs
        frame(0, 5'b00001, 4'h0, 16, "R10");
        // Global and per-channel writes
        frame(1, 5'b00001, 4'b1011, 16, "R2");
        frame(1, 5'b01001, 4'b0101, 16, "R5");
        frame(1, 5'b00101, 4'b1001, 16, "R5");
        frame(1, 5'b01101, 4'b1111, 16, "R5");
        for (int c = 0; c < 4; c++) begin
            frame(1, {c[1:0], 3'b010}, 4'(c + 3), 16, "R4");
            frame(1, {c[1:0], 3'b011}, 4'(12 - c), 16, "R4");
            frame(1, {c[1:0], 3'b100}, 4'(5 * c + 1), 16, "R4");
        end
        // Delayed readback chain
        frame(0, 5'b00001, 4'h0, 16, "R2");
        frame(0, 5'b01001, 4'h0, 16, "R2");
        frame(0, 5'b00101, 4'h0, 16, "R5");
        frame(0, 5'b01101, 4'h0, 16, "R5");
        wd_timeout = 1;
        frame(0, 5'b10010, 4'h0, 16, "R5 wd timeout");
        frame(0, 5'b01011, 4'h0, 16, "R4");
        frame(0, 5'b11100, 4'h0, 16, "R4");
        frame(0, 5'b00110, 4'h0, 16, "R4");
        // Pin groups, undefined addresses, ignored writes
        frame(0, 5'b01110, 4'h0, 16, "R9");
        frame(0, 5'b01111, 4'h0, 16, "R9");
        frame(0, 5'b00111, 4'h0, 16, "R9");
        frame(0, 5'b10001, 4'h0, 16, "R9");
        frame(1, 5'b00110, 4'hF, 16, "R9");
        frame(1, 5'b00111, 4'hF, 16, "R9");
        frame(1, 5'b11000, 4'hF, 16, "R9");
        frame(0, 5'b00001, 4'h0, 16, "R9");
        // R3: wrong-length frames are discarded
        frame(1, 5'b00001, 4'b0000, 15, "R3");
        check("R3 ch_on kept after short frame", ch_on, 4'b1011);
        frame(0, 5'b01001, 4'h0, 16, "R3");
        frame(1, 5'b01001, 4'b1111, 17, "R3");
        check("R3 sense kept after long frame", sense_en, 4'b0101);
        frame(0, 5'b00001, 4'h0, 16, "R3");
        // Faults: R6 order and R7 latching
        pulse(11); pulse(4); pulse(14);
        @(negedge clk);
        check("R7 fault_any set", fault_any, 1);
        frame(0, 5'b10000, 4'h0, 16, "R6");
        frame(0, 5'b01000, 4'h0, 16, "R6");
        frame(0, 5'b11000, 4'h0, 16, "R6");
        frame(0, 5'b00001, 4'h0, 16, "R6");
        // R8: off clears only that channel; simultaneous pulse still sets
        frame(1, 5'b00001, 4'b1011, 16, "R8");
        frame(0, 5'b10000, 4'h0, 16, "R8");
        frame(1, 5'b00001, 4'b0101, 16, "R8", 4);
        check("R8 fault_any after collision", fault_any, 1);
        frame(0, 5'b01000, 4'h0, 16, "R8");
        frame(0, 5'b11000, 4'h0, 16, "R8");
        frame(1, 5'b00001, 4'b0000, 16, "R8");
        check("R8 fault_any cleared", fault_any, 0);
        frame(0, 5'b01000, 4'h0, 16, "R8");
        frame(0, 5'b00000, 4'h0, 16, "R6");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule